// File: doc/BRIEF.md
# Temperature Word to Single-Precision Float Converter

This block takes the 16-bit reading word of a digital temperature sensor and turns it into the bit pattern of an IEEE-754 single-precision number. It uses no multiplier. The word carries three alarm bits and a sign bit. It also carries a 12-bit magnitude in sixteenths of a degree. The block splits off the alarm bits and left-justifies the magnitude in a 16-bit field. It then counts the leading zeros of that field, shifts the field to normalise it, and packs sign, exponent and fraction. Every representable reading fits a single-precision value exactly, so the block never rounds.

A word is offered with a one-cycle valid strobe. One clock later the registered float and the three alarm bits appear together with an output valid. They stay unchanged until the next accepted word.

Top module: `tempword_to_f32`

## Requirements
- R1: The alarm outputs are registered copies of the accepted word: `alarm_crit` = bit 15, `alarm_high` = bit 14, `alarm_low` = bit 13.
- R2: The alarm bits have no effect on `f32_out`. Two words that differ only in bits 15:13 give the same float.
- R3: For a non-zero magnitude, `f32_out[31]` equals bit 12 of the accepted word (1 = negative).
- R4: When bits 11:0 of the accepted word are all zero, `f32_out` is 32'h00000000, whatever bit 12 holds.
- R5: The exponent field `f32_out[30:23]` is 8'h86 minus the leading-zero count of the 16-bit field {bits 11:0, 4'b0000}. For non-zero inputs it therefore lies between 8'h7B (value 1/16) and 8'h86.
- R6: The fraction field `f32_out[22:0]` holds the magnitude bits below the leading one, left-justified with zero fill. The result is the exact value magnitude/16 (for example 0x0190 gives 0x41C80000 and 0x1FF0 gives 0xC37F0000).
- R7: `f32_valid` is high exactly in the cycle after a cycle with `word_valid` high, and `f32_out` and the alarm outputs change in that same cycle.
- R8: While `word_valid` is low, `f32_out` and the alarm outputs keep their values, whatever `word_in` does.
- R9: Synchronous reset clears `f32_valid`, `f32_out` and all alarm outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Strobe: `word_in` is accepted this cycle |
| word_in | input | 16 | Raw sensor word: alarms [15:13], sign [12], magnitude [11:0] in 1/16 degree |
| f32_valid | output | 1 | Registered float and alarms are fresh this cycle |
| f32_out | output | 32 | Single-precision bit pattern of the reading |
| alarm_crit | output | 1 | Registered critical alarm bit |
| alarm_high | output | 1 | Registered upper-limit alarm bit |
| alarm_low | output | 1 | Registered lower-limit alarm bit |

## Verification
The bench aims at the two ends of the exponent range. The smallest magnitude, 1/16, needs the largest shift and exponent 8'h7B, and the full-scale magnitude needs no shift at all. An off-by-one in the leading-zero count or the exponent offset gives results off by a factor of two. A mishandled implicit one leaves a stray fraction bit set. Negative zero must come out as all zeros: a design that copies the sign blindly would give 0x80000000. The bench sweeps every sign and magnitude with the alarm bits varied, so alarm bits that leak into the value show up as wrong floats. It also checks that data and alarms hold while the strobe is low: a design that loads without the strobe would follow `word_in`.

// File: rtl/tw2f_pkg.sv
package tw2f_pkg;

    localparam int WORD_W  = 16;
    localparam int MAG_W   = 12;
    localparam int SUB_W   = 4;
    localparam int ALIGN_W = 16;
    localparam int EXP_W   = 8;
    localparam int MANT_W  = 23;
    localparam int BIAS    = 127;
    localparam int LZ_W    = $clog2(ALIGN_W + 1);
    localparam int EXP_TOP = BIAS + MAG_W - 1 - SUB_W;

    typedef struct packed {
        logic             crit;
        logic             high;
        logic             low;
        logic             neg;
        logic [MAG_W-1:0] mag;
    } temp_word_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] frac;
    } f32_t;

    typedef struct packed {
        logic crit;
        logic high;
        logic low;
    } alarm_t;

    function automatic f32_t make_f32(input logic s, input logic [EXP_W-1:0] e,
                                      input logic [MANT_W-1:0] f);
        f32_t r;
        r.sign = s;
        r.expo = e;
        r.frac = f;
        return r;
    endfunction

endpackage

// File: rtl/tw2f_unpack.sv
module tw2f_unpack
    import tw2f_pkg::*;
#(
    parameter int MW = MAG_W,
    parameter int AW = ALIGN_W
) (
    input  temp_word_t      word,
    output alarm_t          alarms,
    output logic            neg,
    output logic [AW-1:0]   aligned
);
    localparam int PAD = AW - MW;

    always_comb begin
        alarms.crit = word.crit;
        alarms.high = word.high;
        alarms.low  = word.low;
        neg         = word.neg;
        aligned     = {word.mag, {PAD{1'b0}}};
    end
endmodule

// File: rtl/tw2f_lzc.sv
module tw2f_lzc #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count,
    output logic          all_zero
);
    always_comb begin
        count    = CW'(W);
        all_zero = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count    = CW'(W - 1 - i);
                all_zero = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tw2f_pack.sv
module tw2f_pack
    import tw2f_pkg::*;
#(
    parameter int AW = ALIGN_W,
    parameter int CW = LZ_W
) (
    input  logic          neg,
    input  logic [AW-1:0] aligned,
    input  logic [CW-1:0] lz,
    input  logic          is_zero,
    output f32_t          result
);
    localparam int FILL = MANT_W - (AW - 1);

    logic [AW-1:0] stage [0:CW];
    assign stage[0] = aligned;

    genvar k;
    generate
        for (k = 0; k < CW; k++) begin : g_shift
            assign stage[k+1] = lz[k] ? (stage[k] << (1 << k)) : stage[k];
        end
    endgenerate

    logic [AW-1:0]     norm;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] frac;

    always_comb begin
        norm = stage[CW];
        expo = EXP_W'(EXP_TOP) - EXP_W'(lz);
        frac = {norm[AW-2:0], {FILL{1'b0}}};
        if (is_zero) result = '0;
        else         result = make_f32(neg, expo, frac);
    end
endmodule

// File: rtl/tempword_to_f32.sv
module tempword_to_f32
    import tw2f_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        word_valid,
    input  logic [15:0] word_in,
    output logic        f32_valid,
    output logic [31:0] f32_out,
    output logic        alarm_crit,
    output logic        alarm_high,
    output logic        alarm_low
);
    temp_word_t           word;
    alarm_t               alarms;
    logic                 neg;
    logic [ALIGN_W-1:0]   aligned;
    logic [LZ_W-1:0]      lz;
    logic                 is_zero;
    f32_t                 result;

    assign word = word_in;

    tw2f_unpack u_unpack (
        .word    (word),
        .alarms  (alarms),
        .neg     (neg),
        .aligned (aligned)
    );

    tw2f_lzc #(.W(ALIGN_W), .CW(LZ_W)) u_lzc (
        .vec      (aligned),
        .count    (lz),
        .all_zero (is_zero)
    );

    tw2f_pack u_pack (
        .neg     (neg),
        .aligned (aligned),
        .lz      (lz),
        .is_zero (is_zero),
        .result  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            f32_valid  <= 1'b0;
            f32_out    <= '0;
            alarm_crit <= 1'b0;
            alarm_high <= 1'b0;
            alarm_low  <= 1'b0;
        end else begin
            f32_valid <= word_valid;
            if (word_valid) begin
                f32_out    <= result;
                alarm_crit <= alarms.crit;
                alarm_high <= alarms.high;
                alarm_low  <= alarms.low;
            end
        end
    end
endmodule

// File: rtl/tw2f_checker.sv
module tw2f_checker (
    input logic        clk,
    input logic        rst,
    input logic        word_valid,
    input logic [15:0] word_in,
    input logic        f32_valid,
    input logic [31:0] f32_out,
    input logic        alarm_crit,
    input logic        alarm_high,
    input logic        alarm_low
);
    p_alarm_copy_r1: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> {alarm_crit, alarm_high, alarm_low} == $past(word_in[15:13]));

    p_sign_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_in[11:0] != 12'h000) |=> f32_out[31] == $past(word_in[12]));

    p_zero_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_in[11:0] == 12'h000) |=> f32_out == 32'h0);

    p_exp_span_r5: assert property (@(posedge clk) disable iff (rst)
        (f32_valid && f32_out != 32'h0) |-> (f32_out[30:23] >= 8'h7B && f32_out[30:23] <= 8'h86));

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> f32_valid);

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !word_valid |=> !f32_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !word_valid |=> ($stable(f32_out) && $stable({alarm_crit, alarm_high, alarm_low})));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!f32_valid && f32_out == 32'h0 && !alarm_crit && !alarm_high && !alarm_low));
endmodule

bind tempword_to_f32 tw2f_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word_in    (word_in),
    .f32_valid  (f32_valid),
    .f32_out    (f32_out),
    .alarm_crit (alarm_crit),
    .alarm_high (alarm_high),
    .alarm_low  (alarm_low)
);

// File: tb/tempword_to_f32_test.sv
`timescale 1ns/1ps
module tempword_to_f32_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [15:0] word_in = '0;
    logic        f32_valid;
    logic [31:0] f32_out;
    logic        alarm_crit, alarm_high, alarm_low;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tempword_to_f32 uut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .f32_valid(f32_valid), .f32_out(f32_out),
        .alarm_crit(alarm_crit), .alarm_high(alarm_high), .alarm_low(alarm_low)
    );

    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {16'h0190, 32'h41C80000},
        {16'h1FF0, 32'hC37F0000},
        {16'h0001, 32'h3D800000},
        {16'h1001, 32'hBD800000},
        {16'h0FFF, 32'h437FF000},
        {16'h1000, 32'h00000000},
        {16'h0000, 32'h00000000},
        {16'hE010, 32'h3F800000},
        {16'h0018, 32'h3FC00000},
        {16'h0008, 32'h3F000000},
        {16'h1003, 32'hBE400000},
        {16'hA7D0, 32'h42FA0000}
    };

    function automatic logic [31:0] ref_f32(input logic [15:0] w);
        logic [11:0] m;
        int          p;
        logic [31:0] f;
        m = w[11:0];
        p = -1;
        for (int b = 0; b < 12; b++) if (m[b]) p = b;
        if (p < 0) return 32'h0;
        f = (32'(m) << (23 - p)) & 32'h007FFFFF;
        return {w[12], 8'(127 + p - 4), f[22:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        word_valid = 1'b1;
        word_in    = w;
        @(posedge clk);
        #1;
        word_valid = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check(f32_valid == 1'b0, "R9 valid", 32'(f32_valid), 0);
        check(f32_out == 32'h0, "R9 data", f32_out, 0);
        check({alarm_crit, alarm_high, alarm_low} == 3'b000, "R9 alarms",
              32'({alarm_crit, alarm_high, alarm_low}), 0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: R3 R4 R5 R6 R1
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][47:32]);
            check(f32_out == VEC[i][31:0], "R6 value", f32_out, VEC[i][31:0]);
            check({alarm_crit, alarm_high, alarm_low} == VEC[i][47:45], "R1 alarms",
                  32'({alarm_crit, alarm_high, alarm_low}), 32'(VEC[i][47:45]));
            check(f32_valid == 1'b1, "R7 valid", 32'(f32_valid), 1);
        end

        // R4 negative zero against a prior non-zero value
        send(16'h0FFF);
        send(16'h1000);
        check(f32_out == 32'h0, "R4 negzero", f32_out, 0);

        // R5 exponent ends
        send(16'h0001);
        check(f32_out[30:23] == 8'h7B, "R5 low", 32'(f32_out[30:23]), 32'h7B);
        send(16'h1800);
        check(f32_out[30:23] == 8'h86, "R5 high", 32'(f32_out[30:23]), 32'h86);
        check(f32_out[31] == 1'b1, "R3 sign", 32'(f32_out[31]), 1);

        // R2: alarm bits must not alter the value
        send(16'h0190);
        held = f32_out;
        send(16'hE190);
        check(f32_out == held, "R2 flags ignored", f32_out, held);

        // R7: valid drops one cycle after strobe ends
        @(posedge clk);
        #1;
        check(f32_valid == 1'b0, "R7 drop", 32'(f32_valid), 0);

        // R8: hold while strobe low
        held = f32_out;
        @(negedge clk);
        word_in = 16'h5FF0;
        repeat (3) @(posedge clk);
        #1;
        check(f32_out == held, "R8 hold data", f32_out, held);
        check({alarm_crit, alarm_high, alarm_low} == 3'b111, "R8 hold alarms",
              32'({alarm_crit, alarm_high, alarm_low}), 32'h7);

        // exhaustive sweep of sign+magnitude, alarms varied: R2 R3 R4 R5 R6
        for (int i = 0; i < 8192; i++) begin
            logic [15:0] w;
            logic [31:0] e;
            w = {3'(i * 5), i[12:0]};
            e = ref_f32(w);
            send(w);
            check(f32_out == e, "R6 sweep", f32_out, e);
        end

        // R9: reset mid-run
        send(16'hFFFF);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(f32_out == 32'h0 && !f32_valid, "R9 midrun", f32_out, 0);
        check({alarm_crit, alarm_high, alarm_low} == 3'b000, "R9 midrun alarms",
              32'({alarm_crit, alarm_high, alarm_low}), 0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule